// File: doc/BRIEF.md
# Instruction Fetch and Decode Sequencer

This block is the hardwired timing controller of a single-accumulator processor. The processor has a 12-bit address space of 16-bit words. A 4-bit step counter is decoded into sixteen one-hot timing lines. The block drives these steps in order:

- Copy the program counter into the address register.
- Read the instruction word and advance the program counter.
- Split the word into its indirect bit, its 3-bit operation code and its 12-bit address, and decode the operation code into eight one-hot lines.
- For a memory operation with the indirect bit set, replace the address with the word read from that address.

Control then passes to one of three execute units: memory operation, register operation or I/O operation. The active unit answers with a done pulse, which returns the counter to step 0. A run flag gates all progress. The memory read port is synchronous: the block presents an address one cycle before it needs the data.

The block holds the address register, program counter, instruction register, indirect flag and decoded operation lines. It also shows them at its ports, so the execute units and the surrounding datapath can use them.

Top module: `instr_sequencer`

## Requirements
- R1: After reset the step counter is 0 (`tStep` = 16'h0001). The address register, program counter, instruction register, indirect flag and `decOp` are all zero. `runFlag` and the three execute outputs are low.
- R2: A `startReq` pulse sets `runFlag` and a `haltReq` pulse clears it. When both are high in the same cycle, the halt wins. While `runFlag` is 0, the step counter, program counter and address register all hold.
- R3: At step 0, `memAddr` equals the program counter and the address register loads the program counter. At step 1, the instruction register loads `memData` and the program counter increments by one.
- R4: At step 2, `memAddr` carries instruction bits 11..0. At the same step the address register loads those bits, `indFlag` loads instruction bit 15, and `decOp` loads a one-hot code with bit k set for k = instruction bits 14..12.
- R5: At step 3, when `decOp[7]` is 0 and `indFlag` is 1, the address register loads `memData[11:0]`. When `decOp[7]` is 0 and `indFlag` is 0, the address register is unchanged.
- R6: From step 3 onward, `execReg` is high when `decOp[7]` is 1 and `indFlag` is 0, and `execIo` is high when `decOp[7]` is 1 and `indFlag` is 1. From step 4 onward, `execMem` is high when `decOp[7]` is 0. At most one of the three is high at any time.
- R7: `execDone` high while an execute output is high returns the counter to step 0 at the next edge. `execDone` at any other time has no effect on the step sequence.
- R8: While an execute output is high and `execDone` is low, the counter increments each cycle. It saturates at step 15.
- R9: `tStep` is always one-hot, with bit k set when the counter holds k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Sets the run flag |
| haltReq | input | 1 | Clears the run flag; wins over startReq |
| memAddr | output | 12 | Read address to the synchronous memory |
| memData | input | 16 | Read data, one cycle after the address |
| execDone | input | 1 | Execute unit finished; clears the step counter |
| execMem | output | 1 | Memory-operation execute phase active |
| execReg | output | 1 | Register-operation execute phase active |
| execIo | output | 1 | I/O-operation execute phase active |
| tStep | output | 16 | One-hot timing step |
| decOp | output | 8 | One-hot decoded operation code |
| arOut | output | 12 | Address register |
| pcOut | output | 12 | Program counter |
| irOut | output | 16 | Instruction register |
| indFlag | output | 1 | Indirect flag of the current instruction |
| runFlag | output | 1 | Start-stop flag |

## Verification
A corrupted step counter shows up on `tStep` in the same cycle, and on the address register or program counter one edge later, because every load is keyed to one step. A wrong decode or a wrong indirect bit surfaces at step 3 as the wrong execute output, or at step 4 as a wrong address register value. A program counter that slips shows up on `memAddr` at the next step 0. As a result, every fault reaches the ports within one instruction.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Strobes issued by the control to the datapath, one per register transfer
  typedef struct packed {
    logic arFromPc;   // step 0 load
    logic irFromMem;  // step 1 load
    logic pcInc;      // step 1 increment
    logic arFromIr;   // step 2 load, also latches indirect bit and decode
    logic arFromMem;  // step 3 indirect address fetch
    logic addrPc;     // memory address select: program counter
    logic addrIr;     // memory address select: instruction address field
  } strobe_t;
endpackage

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
#(
  parameter int STEP_W = 4,
  localparam int NUM_STEPS = 1 << STEP_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 haltReq,
  input  logic                 execDone,
  input  logic                 opHigh,
  input  logic                 indFlag,
  output strobe_t              strb,
  output logic [NUM_STEPS-1:0] tStep,
  output logic                 runFlag,
  output logic                 execMem,
  output logic                 execReg,
  output logic                 execIo
);
  localparam logic [STEP_W-1:0] MAX_STEP  = STEP_W'(NUM_STEPS - 1);
  localparam logic [STEP_W-1:0] DISPATCH  = STEP_W'(3);
  localparam logic [STEP_W-1:0] MEM_START = STEP_W'(4);

  logic [STEP_W-1:0] stepCnt;
  logic              execActive;

  // Start-stop flag: halt wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         runFlag <= 1'b0;
    else if (haltReq)  runFlag <= 1'b0;
    else if (startReq) runFlag <= 1'b1;
  end

  // Execute hand-off decoded from the operation class and the step
  assign execMem    = !opHigh && (stepCnt >= MEM_START);
  assign execReg    = opHigh && !indFlag && (stepCnt >= DISPATCH);
  assign execIo     = opHigh && indFlag && (stepCnt >= DISPATCH);
  assign execActive = execMem | execReg | execIo;

  // Clearable, saturating step counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
    end else if (runFlag) begin
      if (execActive && execDone) stepCnt <= '0;
      else if (stepCnt != MAX_STEP) stepCnt <= stepCnt + 1'b1;
    end
  end

  // One-hot step decoder
  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
    assign tStep[k] = (stepCnt == STEP_W'(k));
  end

  always_comb begin
    strb           = '0;
    strb.arFromPc  = runFlag && tStep[0];
    strb.irFromMem = runFlag && tStep[1];
    strb.pcInc     = runFlag && tStep[1];
    strb.arFromIr  = runFlag && tStep[2];
    strb.arFromMem = runFlag && tStep[3] && !opHigh && indFlag;
    strb.addrPc    = tStep[0];
    strb.addrIr    = tStep[2];
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OP_W   = 3,
  localparam int WORD_W  = ADDR_W + OP_W + 1,
  localparam int NUM_OPS = 1 << OP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [WORD_W-1:0]  memData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [ADDR_W-1:0]  arOut,
  output logic [ADDR_W-1:0]  pcOut,
  output logic [WORD_W-1:0]  irOut,
  output logic               indFlag,
  output logic [NUM_OPS-1:0] decOp
);
  localparam int IND_BIT = WORD_W - 1;

  logic [ADDR_W-1:0]  arReg, pcReg;
  logic [WORD_W-1:0]  irReg;
  logic               indReg;
  logic [NUM_OPS-1:0] decReg, decNext;
  logic [OP_W-1:0]    opField;

  assign opField = irReg[ADDR_W +: OP_W];

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_opdec
    assign decNext[k] = (opField == OP_W'(k));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arReg  <= '0;
      pcReg  <= '0;
      irReg  <= '0;
      indReg <= 1'b0;
      decReg <= '0;
    end else begin
      if (strb.arFromPc)  arReg <= pcReg;
      if (strb.irFromMem) irReg <= memData;
      if (strb.pcInc)     pcReg <= pcReg + 1'b1;
      if (strb.arFromIr) begin
        arReg  <= irReg[ADDR_W-1:0];
        indReg <= irReg[IND_BIT];
        decReg <= decNext;
      end
      if (strb.arFromMem) arReg <= memData[ADDR_W-1:0];
    end
  end

  // Address goes out one cycle ahead of the data it fetches
  always_comb begin
    if (strb.addrPc)      memAddr = pcReg;
    else if (strb.addrIr) memAddr = irReg[ADDR_W-1:0];
    else                  memAddr = arReg;
  end

  assign arOut   = arReg;
  assign pcOut   = pcReg;
  assign irOut   = irReg;
  assign indFlag = indReg;
  assign decOp   = decReg;
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OP_W   = 3,
  parameter int STEP_W = 4,
  localparam int WORD_W    = ADDR_W + OP_W + 1,
  localparam int NUM_OPS   = 1 << OP_W,
  localparam int NUM_STEPS = 1 << STEP_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 haltReq,
  output logic [ADDR_W-1:0]    memAddr,
  input  logic [WORD_W-1:0]    memData,
  input  logic                 execDone,
  output logic                 execMem,
  output logic                 execReg,
  output logic                 execIo,
  output logic [NUM_STEPS-1:0] tStep,
  output logic [NUM_OPS-1:0]   decOp,
  output logic [ADDR_W-1:0]    arOut,
  output logic [ADDR_W-1:0]    pcOut,
  output logic [WORD_W-1:0]    irOut,
  output logic                 indFlag,
  output logic                 runFlag
);
  strobe_t strb;

  seq_control #(.STEP_W(STEP_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .haltReq  (haltReq),
    .execDone (execDone),
    .opHigh   (decOp[NUM_OPS-1]),
    .indFlag  (indFlag),
    .strb     (strb),
    .tStep    (tStep),
    .runFlag  (runFlag),
    .execMem  (execMem),
    .execReg  (execReg),
    .execIo   (execIo)
  );

  seq_datapath #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .memData (memData),
    .memAddr (memAddr),
    .arOut   (arOut),
    .pcOut   (pcOut),
    .irOut   (irOut),
    .indFlag (indFlag),
    .decOp   (decOp)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int ADDR_W = 12,
  parameter int STEP_W = 4,
  localparam int NUM_STEPS = 1 << STEP_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 haltReq,
  input logic                 execDone,
  input logic                 execMem,
  input logic                 execReg,
  input logic                 execIo,
  input logic [NUM_STEPS-1:0] tStep,
  input logic [ADDR_W-1:0]    arOut,
  input logic [ADDR_W-1:0]    pcOut,
  input logic                 runFlag
);
  p_step_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tStep) == 1);

  p_exec_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({execMem, execReg, execIo}));

  p_halt_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |=> !runFlag);

  p_stopped_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    !runFlag |=> ($stable(tStep) && $stable(pcOut) && $stable(arOut)));

  p_pc_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    (runFlag && tStep[1]) |=> (pcOut == $past(pcOut) + ADDR_W'(1)));

  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (runFlag && execDone && (execMem || execReg || execIo)) |=> tStep[0]);

  p_saturate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (runFlag && tStep[NUM_STEPS-1] && !execDone) |=> tStep[NUM_STEPS-1]);
endmodule

bind instr_sequencer seq_checker #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .haltReq  (haltReq),
  .execDone (execDone),
  .execMem  (execMem),
  .execReg  (execReg),
  .execIo   (execIo),
  .tStep    (tStep),
  .arOut    (arOut),
  .pcOut    (pcOut),
  .runFlag  (runFlag)
);

// File: tb/instr_sequencer_bench.sv
module instr_sequencer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, haltReq = 1'b0, execDone = 1'b0;
  logic [11:0] memAddr;
  logic [15:0] memData;
  logic        execMem, execReg, execIo, indFlag, runFlag;
  logic [15:0] tStep, irOut;
  logic [7:0]  decOp;
  logic [11:0] arOut, pcOut;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [11:0] expPc = '0;
  logic [31:0] salt = 32'h1234_5678;

  always #4 clk = ~clk;  // 125 MHz

  instr_sequencer u_instr_sequencer (.*);

  function automatic logic [15:0] memWord(input logic [11:0] a);
    logic [31:0] x;
    x = ({20'h0, a} * 32'h9E37_79B1) ^ salt;
    return x[27:12] ^ x[15:0];
  endfunction

  // Synchronous memory model: one-cycle read latency
  always_ff @(posedge clk) memData <= memWord(memAddr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepClk();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] stepBit(input int s);
    return 16'h1 << ((s > 15) ? 15 : s);
  endfunction

  task automatic runInstr(input bit doHalt, input int dly);
    logic [15:0] w;
    logic [11:0] expAr;
    int s;
    chk("R9 step0", tStep, 16'h0001);
    chk("R3 addr=pc", memAddr, expPc);
    execDone = 1'($urandom);  // R7: ignored outside execute
    stepClk;
    chk("R3 ar<=pc", arOut, expPc);
    chk("R7 step1", tStep, 16'h0002);
    execDone = 1'($urandom);
    if (doHalt) begin haltReq = 1; startReq = 1; end
    stepClk;
    w = memWord(expPc);
    expPc = expPc + 12'd1;
    chk("R3 ir", irOut, w);
    chk("R3 pc+1", pcOut, expPc);
    chk("R4 addr=ir", memAddr, w[11:0]);
    chk("R7 step2", tStep, 16'h0004);
    if (doHalt) begin
      haltReq = 0; startReq = 0;
      chk("R2 halt wins", runFlag, 0);
      repeat (3) stepClk;
      chk("R2 hold step", tStep, 16'h0004);
      chk("R2 hold pc", pcOut, expPc);
      startReq = 1;
      stepClk;
      startReq = 0;
      chk("R2 restart", {runFlag, tStep}, {1'b1, 16'h0004});
    end
    execDone = 1'($urandom);
    stepClk;
    chk("R4 ar<=addr", arOut, w[11:0]);
    chk("R4 ind", indFlag, w[15]);
    chk("R4 decode", decOp, 8'h1 << w[14:12]);
    chk("R9 step3", tStep, 16'h0008);
    if (w[14:12] == 3'd7) begin
      chk("R6 reg/io", {execMem, execReg, execIo}, {1'b0, !w[15], w[15]});
      s = 3;
    end else begin
      chk("R6 no exec at 3", {execMem, execReg, execIo}, 3'b000);
      execDone = 1;  // R7: ignored, no execute active
      stepClk;
      chk("R7 done ignored", tStep, 16'h0010);
      expAr = w[15] ? memWord(w[11:0]) & 16'h0FFF : w[11:0];
      chk("R5 indirect", arOut, expAr);
      chk("R6 mem exec", {execMem, execReg, execIo}, 3'b100);
      s = 4;
    end
    for (int k = 0; k < dly; k++) begin
      execDone = 0;
      stepClk;
      s++;
      chk("R8 exec count", tStep, stepBit(s));
    end
    execDone = 1;
    stepClk;
    execDone = 0;
    chk("R7 done clears", tStep, 16'h0001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 step", tStep, 16'h0001);
    chk("R1 regs", {pcOut, arOut, irOut, indFlag, decOp}, 0);
    chk("R1 flags", {runFlag, execMem, execReg, execIo}, 4'b0000);
    repeat (3) stepClk;
    chk("R2 idle hold", {tStep, pcOut}, {16'h0001, 12'h000});
    startReq = 1;
    stepClk;
    startReq = 0;
    chk("R2 start", runFlag, 1);
    runInstr(1'b0, 14);  // saturation corner, R8
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) salt = $urandom;
      runInstr(n % 37 == 5, (n % 29 == 3) ? 14 : int'($urandom % 4));
    end
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule